// File: doc/BRIEF.md
# Framed Serial Packet Receiver

This block sits behind a UART byte receiver and turns its stream of bytes into decoded register packets. Bytes arrive on a valid/data interface, one byte per cycle at most, with idle cycles allowed anywhere. The receiver waits for the three-character ASCII marker `s`, `n`, `p`. It then reads a type byte and an address byte, followed by a payload whose length is worked out from the type byte. A two-byte additive checksum closes the packet.

A packet that arrives complete and intact produces a one-cycle `pkt_done` pulse, with the type fields, the address and the payload words on the outputs. A packet whose type byte is illegal, or whose checksum does not match, produces a one-cycle `pkt_err` pulse instead. After either pulse the receiver goes back to hunting for the next marker. Storing the registers and sending replies are left to the logic around it.

Top module: `pkt_rx`

## Requirements
- R1: After reset both `pkt_done` and `pkt_err` are low, and the receiver is hunting for the start marker.
- R2: A packet is recognised only after the consecutive bytes 0x73, 0x6E, 0x70. Any other byte during matching restarts the match, and a 0x73 counts as a fresh first marker byte (so "s s n p" and "s n s n p" both frame a packet). Bytes that are not part of a framed packet produce no output pulse.
- R3: Type byte fields are decoded as follows. Bit 7 is has-data (`pkt_has_data`). Bit 6 is batch (`pkt_is_batch`). Bits 5:2 are the batch length (`pkt_batch_len`). Bit 1 is the hidden-address flag (`pkt_hidden`). Bit 0 is command-failed. The byte after the type byte appears on `pkt_addr`.
- R4: With has-data 0 there are no payload bytes: the checksum follows the address, the packet is 7 bytes long, `pkt_words` is 0 and `pkt_data` is all zero.
- R5: With has-data 1 and batch 0 the payload is 4 bytes, `pkt_words` is 1, and word 0 sits in `pkt_data[31:0]` with the first payload byte in bits 31:24.
- R6: With has-data 1 and batch 1 the payload is 4 × batch-length bytes, and `pkt_words` equals the batch length. Word k sits in `pkt_data[32k+31:32k]`, most significant byte first, and words at or above the count read zero.
- R7: The checksum is the 16-bit wrap-around sum of every earlier byte of the packet, marker bytes included. The first checksum byte on the wire is the high byte. A mismatch gives a `pkt_err` pulse and no `pkt_done`.
- R8: A type byte with command-failed set, or with batch set and a batch length of 0, gives a `pkt_err` pulse in the cycle after the type byte is accepted. No `pkt_done` follows for that packet.
- R9: `pkt_done` and `pkt_err` are single-cycle pulses, never high together. They rise in the cycle after the byte that decides them is accepted. Cycles with `in_valid` low are ignored, however many occur inside a packet.
- R10: After any error the next correctly framed packet is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is present on `in_byte` this cycle |
| in_byte | input | 8 | Received byte |
| pkt_done | output | 1 | One-cycle pulse: a good packet has ended |
| pkt_err | output | 1 | One-cycle pulse: packet dropped (bad type or checksum) |
| pkt_has_data | output | 1 | Decoded has-data bit |
| pkt_is_batch | output | 1 | Decoded batch bit |
| pkt_batch_len | output | 4 | Decoded batch length |
| pkt_hidden | output | 1 | Decoded hidden-address flag |
| pkt_addr | output | 8 | Register address of the packet |
| pkt_words | output | 4 | Number of valid payload words |
| pkt_data | output | 480 | Payload words, word k in bits 32k+31:32k |

## Verification
Every result is due exactly one clock after the posedge that accepts its deciding byte. For a good packet or a checksum error, the deciding byte is the low checksum byte. For an illegal type, it is the type byte itself. The driver notes the bench cycle counter when it presents that byte and queues the expected item with a due cycle one higher. The monitor samples on the falling edge and compares both the contents and the arrival cycle. Any pulse with nothing queued is reported, including pulses caused by noise bytes or broken markers. Idle gaps inside a packet are tested to confirm they shift only the due cycle.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

    // start marker characters, in wire order
    localparam logic [7:0] MARK_A = 8'h73;
    localparam logic [7:0] MARK_B = 8'h6E;
    localparam logic [7:0] MARK_C = 8'h70;
    localparam logic [15:0] HDR_SUM = 16'(MARK_A) + 16'(MARK_B) + 16'(MARK_C);

    // type byte field positions
    localparam int TB_HAS   = 7;
    localparam int TB_BATCH = 6;
    localparam int TB_BL_LO = 2;
    localparam int TB_HID   = 1;
    localparam int TB_CF    = 0;

    localparam int BL_W      = 4;
    localparam int MAX_WORDS = (1 << BL_W) - 1;
    localparam int CNT_W     = BL_W + 2;      // payload byte counter
    localparam int SUM_W     = 16;

    typedef enum logic [2:0] {
        ST_HUNT, ST_M1, ST_M2, ST_TYPE, ST_ADDR, ST_DATA, ST_CKH, ST_CKL
    } rx_st_e;

    typedef struct packed {
        rx_st_e             st;
        logic [SUM_W-1:0]   sum;
        logic [7:0]         ckh;
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   nbytes;
        logic [7:0]         typ;
        logic [7:0]         addr;
        logic               done;
        logic               err;
    } rx_regs_t;

endpackage

// File: rtl/pkt_len_decode.sv
module pkt_len_decode
    import pkt_rx_pkg::*;
(
    input  logic [7:0]       type_byte,
    output logic             legal,
    output logic [CNT_W-1:0] nbytes
);
    logic            has_d;
    logic            batch;
    logic [BL_W-1:0] blen;

    always_comb begin
        has_d = type_byte[TB_HAS];
        batch = type_byte[TB_BATCH];
        blen  = type_byte[TB_BL_LO +: BL_W];
        legal = !type_byte[TB_CF] && !(batch && (blen == '0));
        if (!has_d)
            nbytes = '0;
        else if (batch)
            nbytes = {blen, 2'b00};
        else
            nbytes = CNT_W'(4);
    end
endmodule

// File: rtl/pkt_word_bank.sv
module pkt_word_bank #(
    parameter int WORDS = 15,
    parameter int IW    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               wr_en,
    input  logic [IW-1:0]      wr_idx,
    input  logic [7:0]         wr_byte,
    output logic [WORDS*32-1:0] words
);
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [31:0] w_q;
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                w_q <= '0;
            else if (wr_en && (wr_idx == IW'(g)))
                w_q <= {w_q[23:0], wr_byte};
        end
        assign words[g*32 +: 32] = w_q;
    end
endmodule

// File: rtl/pkt_rx.sv
module pkt_rx
    import pkt_rx_pkg::*;
#(
    parameter int NWORDS = pkt_rx_pkg::MAX_WORDS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [7:0]           in_byte,
    output logic                 pkt_done,
    output logic                 pkt_err,
    output logic                 pkt_has_data,
    output logic                 pkt_is_batch,
    output logic [BL_W-1:0]      pkt_batch_len,
    output logic                 pkt_hidden,
    output logic [7:0]           pkt_addr,
    output logic [BL_W-1:0]      pkt_words,
    output logic [NWORDS*32-1:0] pkt_data
);
    rx_regs_t         r_d, r_q;
    logic             ty_legal;
    logic [CNT_W-1:0] ty_nbytes;
    logic             bank_clr, bank_wr;

    pkt_len_decode u_dec (
        .type_byte (in_byte),
        .legal     (ty_legal),
        .nbytes    (ty_nbytes)
    );

    pkt_word_bank #(.WORDS(NWORDS), .IW(BL_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (bank_clr),
        .wr_en   (bank_wr),
        .wr_idx  (r_q.cnt[CNT_W-1:2]),
        .wr_byte (in_byte),
        .words   (pkt_data)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        bank_clr = 1'b0;
        bank_wr  = 1'b0;
        if (in_valid) begin
            unique case (r_q.st)
                ST_HUNT: if (in_byte == MARK_A) r_d.st = ST_M1;
                ST_M1: begin
                    if (in_byte == MARK_B)      r_d.st = ST_M2;
                    else if (in_byte != MARK_A) r_d.st = ST_HUNT;
                end
                ST_M2: begin
                    if (in_byte == MARK_C) begin
                        r_d.st  = ST_TYPE;
                        r_d.sum = HDR_SUM;
                    end else if (in_byte == MARK_A) begin
                        r_d.st = ST_M1;
                    end else begin
                        r_d.st = ST_HUNT;
                    end
                end
                ST_TYPE: begin
                    if (ty_legal) begin
                        r_d.typ    = in_byte;
                        r_d.nbytes = ty_nbytes;
                        r_d.sum    = r_q.sum + SUM_W'(in_byte);
                        r_d.st     = ST_ADDR;
                        bank_clr   = 1'b1;
                    end else begin
                        r_d.err = 1'b1;
                        r_d.st  = ST_HUNT;
                    end
                end
                ST_ADDR: begin
                    r_d.addr = in_byte;
                    r_d.sum  = r_q.sum + SUM_W'(in_byte);
                    r_d.cnt  = '0;
                    r_d.st   = (r_q.nbytes == '0) ? ST_CKH : ST_DATA;
                end
                ST_DATA: begin
                    bank_wr = 1'b1;
                    r_d.sum = r_q.sum + SUM_W'(in_byte);
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                    if (r_q.cnt == r_q.nbytes - CNT_W'(1)) r_d.st = ST_CKH;
                end
                ST_CKH: begin
                    r_d.ckh = in_byte;
                    r_d.st  = ST_CKL;
                end
                ST_CKL: begin
                    if ({r_q.ckh, in_byte} == r_q.sum) r_d.done = 1'b1;
                    else                               r_d.err  = 1'b1;
                    r_d.st = ST_HUNT;
                end
                default: r_d.st = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_HUNT;
        end else begin
            r_q <= r_d;
        end
    end

    assign pkt_done      = r_q.done;
    assign pkt_err       = r_q.err;
    assign pkt_has_data  = r_q.typ[TB_HAS];
    assign pkt_is_batch  = r_q.typ[TB_BATCH];
    assign pkt_batch_len = r_q.typ[TB_BL_LO +: BL_W];
    assign pkt_hidden    = r_q.typ[TB_HID];
    assign pkt_addr      = r_q.addr;
    assign pkt_words     = r_q.nbytes[CNT_W-1:2];
endmodule

// File: rtl/pkt_rx_checker.sv
module pkt_rx_checker #(
    parameter int BLW    = 4,
    parameter int DATA_W = 480
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              pkt_done,
    input logic              pkt_err,
    input logic              pkt_has_data,
    input logic              pkt_is_batch,
    input logic [BLW-1:0]    pkt_batch_len,
    input logic [BLW-1:0]    pkt_words,
    input logic [DATA_W-1:0] pkt_data
);
    a_r9_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_done && pkt_err));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done);

    a_r9_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done || pkt_err) |-> $past(in_valid));

    a_r8_no_empty_batch: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> !(pkt_is_batch && (pkt_batch_len == '0)));

    a_r6_word_count: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && pkt_has_data && pkt_is_batch) |-> (pkt_words == pkt_batch_len));

    a_r5_single_word: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && pkt_has_data && !pkt_is_batch) |-> (pkt_words == BLW'(1)));

    a_r4_no_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && !pkt_has_data) |-> (pkt_words == '0 && pkt_data == '0));
endmodule

bind pkt_rx pkt_rx_checker u_chk (.*);

// File: tb/pkt_rx_test.sv
module pkt_rx_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [7:0]   in_byte = 8'h00;
    logic         pkt_done, pkt_err, pkt_has_data, pkt_is_batch, pkt_hidden;
    logic [3:0]   pkt_batch_len, pkt_words;
    logic [7:0]   pkt_addr;
    logic [479:0] pkt_data;

    always #4 clk = ~clk;

    pkt_rx uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .pkt_done(pkt_done), .pkt_err(pkt_err), .pkt_has_data(pkt_has_data),
        .pkt_is_batch(pkt_is_batch), .pkt_batch_len(pkt_batch_len),
        .pkt_hidden(pkt_hidden), .pkt_addr(pkt_addr), .pkt_words(pkt_words),
        .pkt_data(pkt_data)
    );

    typedef struct packed {
        logic [1:0]   kind;     // 0 good, 1 checksum error, 2 type error
        logic [7:0]   typ;
        logic [7:0]   addr;
        logic [3:0]   nw;
        logic [479:0] data;
        logic [31:0]  due;
    } exp_t;

    exp_t        q_exp[$];
    exp_t        e;
    int          n_tests = 0;
    int          n_fail  = 0;
    int          gap     = 0;
    logic [31:0] cyc     = 0;
    bit          finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic put_byte(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = 8'h00;
        repeat (gap) @(negedge clk);
    endtask

    // mode 0: good, 1: corrupt low checksum byte, 2: swap checksum bytes
    task automatic send_pkt(input logic [7:0] typ, input logic [7:0] addr,
                            input logic [479:0] data, input int mode);
        logic [15:0] s;
        logic [7:0]  hi, lo;
        exp_t        it;
        int          nb;
        nb = typ[7] ? (typ[6] ? 4 * int'(typ[5:2]) : 4) : 0;
        s  = 16'h0000;
        it = '0;
        it.typ  = typ;
        it.addr = addr;
        it.nw   = 4'(nb / 4);
        for (int k = 0; k < nb / 4; k++) it.data[32*k +: 32] = data[32*k +: 32];
        put_byte(8'h73); s = s + 16'h73;
        put_byte(8'h6E); s = s + 16'h6E;
        put_byte(8'h70); s = s + 16'h70;
        put_byte(typ);   s = s + 16'(typ);
        put_byte(addr);  s = s + 16'(addr);
        for (int i = 0; i < nb; i++) begin
            logic [7:0] b;
            b = data[32*(i/4) + 24 - 8*(i%4) +: 8];
            put_byte(b);
            s = s + 16'(b);
        end
        hi = s[15:8];
        lo = s[7:0];
        if (mode == 1) begin
            lo = lo ^ 8'h01;
            it.kind = 2'd1;
        end else if (mode == 2 && hi != lo) begin
            hi = s[7:0];
            lo = s[15:8];
            it.kind = 2'd1;
        end
        put_byte(hi);
        it.due = cyc + 1;
        q_exp.push_back(it);
        put_byte(lo);
    endtask

    task automatic send_bad_type(input logic [7:0] typ);
        exp_t it;
        it = '0;
        it.kind = 2'd2;
        put_byte(8'h73);
        put_byte(8'h6E);
        put_byte(8'h70);
        it.due = cyc + 1;
        q_exp.push_back(it);
        put_byte(typ);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (pkt_done || pkt_err)) begin
            if (q_exp.size() == 0) begin
                chk(1'b0, "R2 unexpected pulse", {62'd0, pkt_done, pkt_err}, 64'd0);
            end else begin
                e = q_exp.pop_front();
                chk(cyc == e.due, "R9 result cycle", 64'(cyc), 64'(e.due));
                chk(!(pkt_done && pkt_err), "R9 exclusive", {62'd0, pkt_done, pkt_err}, 64'd0);
                if (e.kind == 2'd2)
                    chk(pkt_err && !pkt_done, "R8 bad type error", {62'd0, pkt_done, pkt_err}, 64'd1);
                else if (e.kind == 2'd1)
                    chk(pkt_err && !pkt_done, "R7 checksum error", {62'd0, pkt_done, pkt_err}, 64'd1);
                else begin
                    chk(pkt_done && !pkt_err, "R7 checksum accept", {62'd0, pkt_done, pkt_err}, 64'd2);
                    chk({pkt_has_data, pkt_is_batch, pkt_batch_len, pkt_hidden} == {e.typ[7:1]},
                        "R3 type fields",
                        64'({pkt_has_data, pkt_is_batch, pkt_batch_len, pkt_hidden}), 64'(e.typ[7:1]));
                    chk(pkt_addr == e.addr, "R3 address", 64'(pkt_addr), 64'(e.addr));
                    chk(pkt_words == e.nw,
                        (e.nw == 0) ? "R4 word count" : (e.nw == 1 && !e.typ[6]) ? "R5 word count" : "R6 word count",
                        64'(pkt_words), 64'(e.nw));
                    for (int k = 0; k < 15; k++) begin
                        if (pkt_data[32*k +: 32] != e.data[32*k +: 32])
                            chk(1'b0, (e.nw == 0) ? "R4 payload" : (e.typ[6] ? "R6 payload" : "R5 payload"),
                                64'(pkt_data[32*k +: 32]), 64'(e.data[32*k +: 32]));
                    end
                    n_tests++;
                end
            end
        end
    end

    initial begin
        logic [479:0] d;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(pkt_done == 1'b0, "R1 done after reset", 64'(pkt_done), 64'd0);
        chk(pkt_err == 1'b0, "R1 err after reset", 64'(pkt_err), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!pkt_done && !pkt_err, "R1 idle after release", {62'd0, pkt_done, pkt_err}, 64'd0);

        // R4 / R3: read without data, then hidden read
        send_pkt(8'h00, 8'hAA, '0, 0);
        send_pkt(8'h02, 8'h11, '0, 0);
        // R5: single register write
        d = '0; d[31:0] = 32'hDEADBEEF;
        send_pkt(8'h80, 8'h05, d, 0);
        // R6: batch write of 3 registers
        d = '0;
        for (int k = 0; k < 3; k++) d[32*k +: 32] = 32'hA0B0C0D0 + 32'(k) * 32'h01010101;
        send_pkt(8'hCC, 8'h20, d, 0);
        // R6: longest batch, 15 registers, hidden flag set
        for (int k = 0; k < 15; k++) d[32*k +: 32] = 32'h01020304 + 32'(k) * 32'h11111111;
        send_pkt(8'hFE, 8'h40, d, 0);
        // R4: batch read carries no payload
        send_pkt(8'h48, 8'h60, '0, 0);

        // R2: noise and broken markers
        put_byte(8'h6E); put_byte(8'h70); put_byte(8'h00);
        put_byte(8'h73);                       // gives "s s n p"
        send_pkt(8'h80, 8'h01, {448'd0, 32'h12345678}, 0);
        put_byte(8'h73); put_byte(8'h6E);      // gives "s n s n p"
        send_pkt(8'h80, 8'h02, {448'd0, 32'h9ABCDEF0}, 0);
        put_byte(8'h73); put_byte(8'h6E); put_byte(8'h55);
        send_pkt(8'h00, 8'h03, '0, 0);
        repeat (5) @(negedge clk);
        chk(q_exp.size() == 0, "R2 no stray results", 64'(q_exp.size()), 64'd0);

        // R7: checksum errors, each followed by a good packet (R10)
        send_pkt(8'h80, 8'h07, {448'd0, 32'hCAFEF00D}, 1);
        send_pkt(8'h80, 8'h08, {448'd0, 32'h0BADF00D}, 0);
        send_pkt(8'h80, 8'h09, {448'd0, 32'hFFFFFFFF}, 2);
        send_pkt(8'h00, 8'h0A, '0, 0);

        // R8: illegal type bytes, then resync (R10)
        send_bad_type(8'h81);
        send_bad_type(8'hC0);
        send_bad_type(8'h41);
        send_pkt(8'hC4, 8'h30, {448'd0, 32'h55AA55AA}, 0);

        // R9: idle gaps inside a packet
        gap = 2;
        d = '0; d[31:0] = 32'h13579BDF; d[63:32] = 32'h2468ACE0;
        send_pkt(8'hC8, 8'h50, d, 0);
        send_pkt(8'h81 & 8'hFE, 8'h51, {448'd0, 32'h00000001}, 1);
        gap = 0;

        repeat (10) @(negedge clk);
        chk(q_exp.size() == 0, "R9 all results arrived", 64'(q_exp.size()), 64'd0);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule